// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This block sits at the front of a single-precision fused multiply-accumulate unit. The unit computes `acc + b*c` in add mode and `acc - b*c` in subtract mode. The block inspects the three 32-bit operands in one clock. When a special operand fixes the final answer on its own, the block produces that answer and the invalid-operation flag. Such operands are a NaN, an infinite product, an infinite accumulator, or an infinity times zero. In that case it also raises a bypass indication, so that the downstream align/add/round datapath's result and flags are discarded. When no special case applies, the operands and the add/subtract select are handed to the datapath with a valid strobe.

Two NaN conventions are selectable at run time.
- **Quieting mode:**
  - When several operands are NaN, the accumulator wins first, then `c`, then `b`.
  - The chosen NaN is returned with its quiet bit set.
  - Any signaling operand raises invalid.
- **Legacy mode:**
  - When several operands are NaN, `b` wins first, then `c`, then the accumulator.
  - The chosen NaN is returned bit-exact, even when it is signaling.
  - No flag is ever raised.

All outputs are registered, one cycle after the inputs.

Top module: `fmasc_resolver`

## Requirements
- R1: `out_valid` equals `in_valid` from one clock earlier. While reset (`rst_n` low) is held, and after it, `out_valid`, `bypass`, `invalid` and `dp_valid` are 0 until a valid input arrives.
- R2: If no operand is NaN, the product is finite and the accumulator is finite, then the following hold:
  - `bypass` and `invalid` are 0.
  - `dp_valid` is 1.
  - `dp_acc`, `dp_b`, `dp_c` and `dp_sub` equal the inputs of the previous cycle.
- R3: In quieting mode (`legacy_mode`=0), if any operand is NaN, the first of these that is NaN is returned: accumulator, then `c`, then `b`. It is returned with mantissa bit 22 (the quiet bit) forced to 1, and `bypass`=1.
- R4: In legacy mode (`legacy_mode`=1), if any operand is NaN, the first of these that is NaN is returned unchanged: `b`, then `c`, then accumulator. `bypass`=1.
- R5: In quieting mode with a NaN operand present, `invalid` is 1 exactly when at least one operand is a signaling NaN or the product is infinity times zero. A signaling NaN has exponent all ones, bit 22 = 0 and a nonzero mantissa.
- R6: In legacy mode `invalid` is always 0.
- R7: Infinity times zero (either order, any signs) with a non-NaN accumulator returns the default NaN 0x7fc00000 with `bypass`=1. `invalid` is 1 in quieting mode.
- R8: An infinite product has effective sign `sign(b) ^ sign(c) ^ op_sub`. If the accumulator is infinite with the opposite sign, the result is 0x7fc00000 with `bypass`=1 and `invalid` = !`legacy_mode`.
- R9: Otherwise, an infinite product returns infinity of the effective sign. A finite product with an infinite accumulator returns the accumulator. Both cases give `bypass`=1 and `invalid`=0.
- R10: `dp_valid` is 1 exactly when `out_valid` is 1 and `bypass` is 0. `bypass` and `invalid` are never 1 without `out_valid`, and `invalid` is never 1 without `bypass`.
- R11: A subnormal operand (exponent 0, nonzero mantissa) counts as finite and nonzero. Infinity times a subnormal is an infinite product, not an invalid one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| op_sub | input | 1 | 1: acc - b*c, 0: acc + b*c |
| legacy_mode | input | 1 | 1: legacy NaN convention, 0: quieting convention |
| acc_in | input | 32 | Accumulator operand |
| b_in | input | 32 | First multiplicand |
| c_in | input | 32 | Second multiplicand |
| out_valid | output | 1 | Registered result valid |
| bypass | output | 1 | Result forced; ignore datapath result and flags |
| invalid | output | 1 | Invalid-operation flag of the forced result |
| forced_res | output | 32 | Forced result value |
| dp_valid | output | 1 | Operands handed to the arithmetic datapath |
| dp_sub | output | 1 | Registered add/subtract select for the datapath |
| dp_acc | output | 32 | Registered accumulator for the datapath |
| dp_b | output | 32 | Registered multiplicand b for the datapath |
| dp_c | output | 32 | Registered multiplicand c for the datapath |

## Verification
NaN selection and invalid-product detection can both apply to one operation. Infinity times zero with a quiet or signaling accumulator NaN must return the NaN while the product still drives the flag. NaN priority and quieting can also meet: a higher-priority quiet operand is returned while a lower-priority signaling operand still raises invalid. The sweep drives every triple from a pool that holds zeros, subnormals, normals, infinities and NaNs of both kinds with distinct payloads, in both modes and both add/subtract selects. It judges value, bypass and flag against an independent model. Directed vectors then pin down these exact collisions.

// File: rtl/fmasc_pkg.sv
package fmasc_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_QNAN,
        CLS_SNAN
    } opcls_e;

endpackage

// File: rtl/fmasc_classify.sv
module fmasc_classify
    import fmasc_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] val,
    output opcls_e               cls
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] man;

    assign ex  = val[W-2 -: EXP_W];
    assign man = val[MAN_W-1:0];

    always_comb begin
        if (~|ex) begin
            cls = (~|man) ? CLS_ZERO : CLS_SUB;
        end else if (&ex) begin
            if (~|man)               cls = CLS_INF;
            else if (man[MAN_W-1])   cls = CLS_QNAN;
            else                     cls = CLS_SNAN;
        end else begin
            cls = CLS_NORM;
        end
    end

endmodule

// File: rtl/fmasc_nan_pick.sv
module fmasc_nan_pick #(
    parameter int W = 32
) (
    input  logic [W-1:0] v_acc,
    input  logic [W-1:0] v_b,
    input  logic [W-1:0] v_c,
    input  logic         n_acc,
    input  logic         n_b,
    input  logic         n_c,
    input  logic         legacy,
    output logic [W-1:0] picked,
    output logic         found
);
    always_comb begin
        found  = n_acc | n_b | n_c;
        picked = '0;
        if (legacy) begin
            // legacy order: b, c, accumulator
            if (n_b)        picked = v_b;
            else if (n_c)   picked = v_c;
            else if (n_acc) picked = v_acc;
        end else begin
            // quieting order: accumulator, c, b
            if (n_acc)      picked = v_acc;
            else if (n_c)   picked = v_c;
            else if (n_b)   picked = v_b;
        end
    end

endmodule

// File: rtl/fmasc_resolver.sv
module fmasc_resolver
    import fmasc_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   op_sub,
    input  logic                   legacy_mode,
    input  logic [EXP_W+MAN_W:0]   acc_in,
    input  logic [EXP_W+MAN_W:0]   b_in,
    input  logic [EXP_W+MAN_W:0]   c_in,
    output logic                   out_valid,
    output logic                   bypass,
    output logic                   invalid,
    output logic [EXP_W+MAN_W:0]   forced_res,
    output logic                   dp_valid,
    output logic                   dp_sub,
    output logic [EXP_W+MAN_W:0]   dp_acc,
    output logic [EXP_W+MAN_W:0]   dp_b,
    output logic [EXP_W+MAN_W:0]   dp_c
);
    localparam int NOPS = 3;
    localparam int W    = 1 + EXP_W + MAN_W;
    localparam int QBIT = MAN_W - 1;
    localparam logic [W-1:0] QMASK   = {{(EXP_W+1){1'b0}}, 1'b1, {(MAN_W-1){1'b0}}};
    localparam logic [W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    typedef struct packed {
        logic         valid;
        logic         bypass;
        logic         invalid;
        logic [W-1:0] forced;
        logic         sub;
        logic [W-1:0] acc;
        logic [W-1:0] b;
        logic [W-1:0] c;
    } stage_t;

    // operand index: 0 = accumulator, 1 = b, 2 = c
    logic [W-1:0] opv [NOPS];
    opcls_e       cls [NOPS];
    logic [NOPS-1:0] is_nan, is_snan, is_inf, is_zero;

    assign opv[0] = acc_in;
    assign opv[1] = b_in;
    assign opv[2] = c_in;

    for (genvar gi = 0; gi < NOPS; gi++) begin : g_cls
        fmasc_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .val (opv[gi]),
            .cls (cls[gi])
        );
        assign is_snan[gi] = (cls[gi] == CLS_SNAN);
        assign is_nan[gi]  = (cls[gi] == CLS_QNAN) || is_snan[gi];
        assign is_inf[gi]  = (cls[gi] == CLS_INF);
        assign is_zero[gi] = (cls[gi] == CLS_ZERO);
    end

    logic [W-1:0] nan_pick;
    logic         nan_found;

    fmasc_nan_pick #(.W(W)) u_pick (
        .v_acc  (acc_in),
        .v_b    (b_in),
        .v_c    (c_in),
        .n_acc  (is_nan[0]),
        .n_b    (is_nan[1]),
        .n_c    (is_nan[2]),
        .legacy (legacy_mode),
        .picked (nan_pick),
        .found  (nan_found)
    );

    logic inf_zero, prod_inf, prod_sgn, inf_cancel, any_snan;

    always_comb begin
        any_snan   = |is_snan;
        inf_zero   = (is_inf[1] & is_zero[2]) | (is_zero[1] & is_inf[2]);
        prod_inf   = (is_inf[1] | is_inf[2]) & ~inf_zero;
        prod_sgn   = b_in[W-1] ^ c_in[W-1] ^ op_sub;
        inf_cancel = prod_inf & is_inf[0] & (acc_in[W-1] != prod_sgn);
    end

    stage_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.valid   = in_valid;
        st_d.bypass  = 1'b0;
        st_d.invalid = 1'b0;
        if (in_valid) begin
            st_d.forced = '0;
            st_d.sub    = op_sub;
            st_d.acc    = acc_in;
            st_d.b      = b_in;
            st_d.c      = c_in;
            if (nan_found) begin
                st_d.bypass  = 1'b1;
                st_d.forced  = legacy_mode ? nan_pick : (nan_pick | QMASK);
                st_d.invalid = ~legacy_mode & (any_snan | inf_zero);
            end else if (inf_zero || inf_cancel) begin
                st_d.bypass  = 1'b1;
                st_d.forced  = DEF_NAN;
                st_d.invalid = ~legacy_mode;
            end else if (prod_inf) begin
                st_d.bypass  = 1'b1;
                st_d.forced  = {prod_sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            end else if (is_inf[0]) begin
                st_d.bypass  = 1'b1;
                st_d.forced  = acc_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign bypass     = st_q.bypass;
    assign invalid    = st_q.invalid;
    assign forced_res = st_q.forced;
    assign dp_valid   = st_q.valid & ~st_q.bypass;
    assign dp_sub     = st_q.sub;
    assign dp_acc     = st_q.acc;
    assign dp_b       = st_q.b;
    assign dp_c       = st_q.c;

    // ---------------- assertions ----------------
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    a_r10_bypass_valid: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> out_valid);

    a_r10_flag_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> bypass);

    a_r6_legacy_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(legacy_mode)) |-> !invalid);

    a_r3_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && !$past(legacy_mode) && (&forced_res[W-2 -: EXP_W])
         && (|forced_res[MAN_W-1:0])) |-> forced_res[QBIT]);

    a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        dp_valid |-> (dp_acc == $past(acc_in) && dp_b == $past(b_in)
                      && dp_c == $past(c_in) && dp_sub == $past(op_sub)));

endmodule

// File: tb/fmasc_resolver_tb.sv
`timescale 1ns/1ps
module fmasc_resolver_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, op_sub, legacy_mode;
    logic [31:0] acc_in, b_in, c_in;
    logic        out_valid, bypass, invalid, dp_valid, dp_sub;
    logic [31:0] forced_res, dp_acc, dp_b, dp_c;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    fmasc_resolver u_dut (
        .clk, .rst_n, .in_valid, .op_sub, .legacy_mode,
        .acc_in, .b_in, .c_in,
        .out_valid, .bypass, .invalid, .forced_res,
        .dp_valid, .dp_sub, .dp_acc, .dp_b, .dp_c
    );

    localparam int NPOOL = 13;
    logic [31:0] pool [NPOOL] = '{
        32'h0000_0000, 32'h8000_0000, 32'h3f80_0000, 32'hbfc0_0000,
        32'h0000_0001, 32'h807f_ffff, 32'h7f7f_ffff, 32'h7f80_0000,
        32'hff80_0000, 32'h7fc0_0001, 32'hffc0_0002, 32'h7f80_0001,
        32'h7fbf_ffff
    };

    function automatic bit f_nan(input logic [31:0] x);
        return (x[30:23] == 8'hff) && (x[22:0] != 0);
    endfunction
    function automatic bit f_snan(input logic [31:0] x);
        return f_nan(x) && !x[22];
    endfunction
    function automatic bit f_inf(input logic [31:0] x);
        return x[30:0] == 31'h7f80_0000;
    endfunction
    function automatic bit f_zero(input logic [31:0] x);
        return x[30:0] == 0;
    endfunction

    // returns {bypass, invalid, value}; value meaningful only with bypass
    function automatic logic [33:0] f_model(input logic [31:0] a, p, q,
                                            input logic sub, leg);
        bit pz, pi, ps, any_s;
        logic [31:0] sel;
        pz    = f_zero(p) || f_zero(q);
        pi    = f_inf(p) || f_inf(q);
        ps    = p[31] ^ q[31] ^ sub;
        any_s = f_snan(a) || f_snan(p) || f_snan(q);
        if (f_nan(a) || f_nan(p) || f_nan(q)) begin
            if (leg) sel = f_nan(p) ? p : (f_nan(q) ? q : a);
            else     sel = f_nan(a) ? a : (f_nan(q) ? q : p);
            if (leg) return {2'b10, sel};
            return {1'b1, any_s || (pi && pz), sel | 32'h0040_0000};
        end
        if (pi && pz) return {1'b1, !leg, 32'h7fc0_0000};
        if (pi) begin
            if (f_inf(a) && a[31] != ps) return {1'b1, !leg, 32'h7fc0_0000};
            return {2'b10, ps, 31'h7f80_0000};
        end
        if (f_inf(a)) return {2'b10, a};
        return {2'b00, 32'h0};
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge: drive, wait one clock, compare against model
    task automatic run_vec(input logic [31:0] a, p, q, input logic sub, leg,
                           input string tag);
        logic [33:0] m;
        acc_in = a; b_in = p; c_in = q; op_sub = sub; legacy_mode = leg;
        in_valid = 1'b1;
        m = f_model(a, p, q, sub, leg);
        @(negedge clk);
        if (m[33])
            chk(tag, {out_valid, bypass, invalid, dp_valid, forced_res},
                     {1'b1, 1'b1, m[32], 1'b0, m[31:0]});
        else
            chk(tag, {out_valid, bypass, invalid, dp_valid, dp_sub, dp_acc, dp_b, dp_c},
                     {1'b1, 1'b0, 1'b0, 1'b1, sub, a, p, q});
    endtask

    function automatic string f_tag(input logic [31:0] a, p, q, input logic leg);
        if (f_nan(a) || f_nan(p) || f_nan(q)) return leg ? "R4/R6" : "R3/R5";
        if ((f_inf(p) || f_inf(q)) && (f_zero(p) || f_zero(q))) return "R7";
        if (f_inf(p) || f_inf(q) || f_inf(a)) return "R8/R9/R11";
        return "R2/R10";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; op_sub = 1'b0; legacy_mode = 1'b0;
        acc_in = '0; b_in = '0; c_in = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset", {out_valid, bypass, invalid, dp_valid}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {out_valid, bypass, invalid, dp_valid}, 4'b0000);

        // sweep all triples, both modes, both operations
        for (int md = 0; md < 4; md++)
            for (int ia = 0; ia < NPOOL; ia++)
                for (int ib = 0; ib < NPOOL; ib++)
                    for (int ic = 0; ic < NPOOL; ic++)
                        run_vec(pool[ia], pool[ib], pool[ic], md[0], md[1],
                                f_tag(pool[ia], pool[ib], pool[ic], md[1]));

        // directed collisions
        run_vec(32'h7fc0_0001, 32'h7fbf_ffff, 32'h3f80_0000, 1'b0, 1'b0, "R3 R5 quiet acc wins, snan b flags");
        chk("R5 flag", {31'h0, invalid}, 32'h1);
        run_vec(32'h7fc0_0001, 32'h7f80_0002, 32'h3f80_0000, 1'b0, 1'b1, "R4 R6 legacy snan b exact");
        chk("R4 value", {96'h0, forced_res}, {96'h0, 32'h7f80_0002});
        run_vec(32'h3f80_0000, 32'h7fc0_0002, 32'h7fc0_0003, 1'b0, 1'b0, "R3 c beats b");
        chk("R3 value", {96'h0, forced_res}, {96'h0, 32'h7fc0_0003});
        run_vec(32'h7f80_0001, 32'h7f80_0000, 32'h0000_0000, 1'b0, 1'b0, "R5 R7 inf*0 + snan acc");
        chk("R5 value", {95'h0, invalid, forced_res}, {95'h0, 1'b1, 32'h7fc0_0001});
        run_vec(32'h7f80_0001, 32'h7f80_0000, 32'h0000_0000, 1'b0, 1'b1, "R6 legacy inf*0 + snan acc");
        chk("R6 value", {95'h0, invalid, forced_res}, {95'h0, 1'b0, 32'h7f80_0001});
        run_vec(32'h3f80_0000, 32'h7f80_0000, 32'h8000_0000, 1'b0, 1'b1, "R7 legacy inf*0 no flag");
        run_vec(32'h7f80_0000, 32'h7f80_0000, 32'h3f80_0000, 1'b1, 1'b0, "R8 msub inf-inf");
        chk("R8 value", {95'h0, invalid, forced_res}, {95'h0, 1'b1, 32'h7fc0_0000});
        run_vec(32'hff80_0000, 32'h7f80_0000, 32'h3f80_0000, 1'b1, 1'b0, "R9 msub same sign inf");
        chk("R9 value", {96'h0, forced_res}, {96'h0, 32'hff80_0000});
        run_vec(32'h3f80_0000, 32'h7f80_0000, 32'h0000_0001, 1'b0, 1'b0, "R11 inf*subnormal");
        chk("R11 value", {95'h0, invalid, forced_res}, {95'h0, 1'b0, 32'h7f80_0000});
        run_vec(32'hbf80_0002, 32'h3f80_0001, 32'h3f80_0001, 1'b0, 1'b0, "R2 R10 finite passthrough");
        chk("R10 dp_valid", {126'h0, dp_valid, bypass}, {126'h0, 2'b10});

        // R1: valid drops one cycle after input valid drops
        in_valid = 1'b0;
        @(negedge clk);
        chk("R1 valid drop", {out_valid, bypass, invalid, dp_valid}, 4'b0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule